// File: doc/BRIEF.md
# Differential Alert Link Receiver

This block sits at the receiving end of a two-wire alert link. The remote sender signals an alert by raising the level of a complementary pair. The receiver answers with its own complementary acknowledge pair, holds it while the alert stays high, and releases it once the alert level drops. It then waits two pause cycles before it accepts another alert. The same handshake carries liveness probes. The receiver flips the level of a complementary probe pair, and the next handshake from the sender counts as the answer to that probe rather than as a real alert.

An integrity failure on the incoming pair is reported at once and also raises the alert output. An integrity failure means both wires are at the same level. The receiver can also reset the far end in band. It drives both of its outgoing pairs to equal levels, and it stays there until the sender answers with equal levels on the alert pair. Six legal states are kept in a three-bit register, and the two spare codes lead back to Idle.

Top module: `diff_alert_rx`

## Requirements
- R1: After reset the probe pair reads level 0 (p=0, n=1) and the acknowledge pair reads level 0 (p=0, n=1). alert_o, ping_ok_o and integ_fail_o are low.
- R2: In Idle, with no probe outstanding, a rise of the alert level (p=1, n=0) raises alert_o in that same cycle. The acknowledge pair reads level 1 from the next cycle on and holds there until the alert level falls.
- R3: The acknowledge pair returns to level 0 in the cycle after the fall is seen. Two pause cycles follow. An alert rise during the pause is not reported, and no acknowledge is given for it.
- R4: When ping_req_i is high and no probe is outstanding, the probe level flips in the next cycle. It flips only once for each request, even if the request stays high.
- R5: A handshake that starts while a probe is outstanding does not raise alert_o. ping_ok_o pulses for one cycle in the cycle where that handshake's fall is seen. A handshake that starts in the same cycle as the probe request is reported as an alert and gives no ping_ok_o.
- R6: Equal levels on the alert pair outside initialisation raise integ_fail_o and alert_o in the same cycle. They do not count as a fall, so a held acknowledge stays at level 1.
- R7: init_i in Idle moves the block to initialisation in the next cycle. From then on all four probe and acknowledge wires read 1, and integ_fail_o and alert_o stay low. The block returns to Idle in the cycle after equal levels are seen on the alert pair, once the first init cycle has passed. It then drives the pairs normally again.
- R8: After every handshake or initialisation the block is back in Idle and reports a new alert rise. The next-state logic yields only the six legal state codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alert_p_i | input | 1 | Alert pair, true wire |
| alert_n_i | input | 1 | Alert pair, complement wire |
| ping_req_i | input | 1 | Probe request, held until ping_ok_o |
| init_i | input | 1 | Starts an in-band link initialisation |
| ping_p_o | output | 1 | Probe pair, true wire |
| ping_n_o | output | 1 | Probe pair, complement wire |
| ack_p_o | output | 1 | Acknowledge pair, true wire |
| ack_n_o | output | 1 | Acknowledge pair, complement wire |
| alert_o | output | 1 | Alert received (pulse) |
| ping_ok_o | output | 1 | Probe answered (one-cycle pulse) |
| integ_fail_o | output | 1 | Alert pair integrity failure |

## Verification
A probe request and a genuine alert can both arrive in the same Idle cycle. The bench provokes this by raising ping_req_i and the alert pair together. It then expects alert_o in that cycle and a probe flip one cycle later. It also expects no ping_ok_o at the end of that first handshake, and ping_ok_o only at the fall of the second handshake, which answers the probe. An integrity failure in the middle of a held acknowledge is checked the same way: the failure flag must rise while the acknowledge stays high.

// File: rtl/dar_pkg.sv
package dar_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_ACK       = 3'd1,
    ST_GAP0      = 3'd2,
    ST_GAP1      = 3'd3,
    ST_INIT_REQ  = 3'd4,
    ST_INIT_WAIT = 3'd5
  } rx_state_t;

  localparam int unsigned NUM_LEGAL = 6;

  function automatic logic pair_level(input logic p, input logic n);
    return p & ~n;
  endfunction

  function automatic logic pair_broken(input logic p, input logic n);
    return ~(p ^ n);
  endfunction

  function automatic logic is_init(input rx_state_t s);
    return (s == ST_INIT_REQ) || (s == ST_INIT_WAIT);
  endfunction

  function automatic logic is_legal(input rx_state_t s);
    return 32'(s) < NUM_LEGAL;
  endfunction

endpackage

// File: rtl/dar_pair_dec.sv
module dar_pair_dec
  import dar_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic p_i,
  input  logic n_i,
  output logic rise_o,
  output logic fall_o,
  output logic broken_o
);

  logic level_q;
  logic cur_level;

  assign cur_level = pair_level(p_i, n_i);
  assign broken_o  = pair_broken(p_i, n_i);
  assign rise_o    = ~broken_o & cur_level & ~level_q;
  assign fall_o    = ~broken_o & ~cur_level & level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else if (!broken_o) level_q <= cur_level;
  end

  // R6
  broken_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    broken_o |=> level_q == $past(level_q));

endmodule

// File: rtl/dar_ping_ctl.sv
module dar_ping_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic ok_i,
  input  logic hold_i,
  output logic level_o,
  output logic pend_o
);

  logic level_q, pend_q, served_q;
  logic start;

  assign start   = req_i & ~pend_q & ~served_q & ~hold_i;
  assign level_o = level_q;
  assign pend_o  = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q  <= 1'b0;
      pend_q   <= 1'b0;
      served_q <= 1'b0;
    end else begin
      if (start) level_q <= ~level_q;
      if (hold_i || ok_i) pend_q <= 1'b0;
      else if (start) pend_q <= 1'b1;
      if (!req_i) served_q <= 1'b0;
      else if (ok_i) served_q <= 1'b1;
    end
  end

  // R4
  flip_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != $past(level_q)) |-> pend_q);

endmodule

// File: rtl/dar_rx_fsm.sv
module dar_rx_fsm
  import dar_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rise_i,
  input  logic      fall_i,
  input  logic      broken_i,
  input  logic      init_i,
  input  logic      pend_i,
  output rx_state_t state_o,
  output logic      ack_o,
  output logic      alert_o,
  output logic      ping_ok_o,
  output logic      integ_o
);

  rx_state_t state_q, state_d;
  logic      hs_ping_q;
  logic      hs_start;

  assign hs_start = (state_q == ST_IDLE) & ~init_i & rise_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (init_i) state_d = ST_INIT_REQ;
        else if (rise_i) state_d = ST_ACK;
      end
      ST_ACK:       if (fall_i) state_d = ST_GAP0;
      ST_GAP0:      state_d = ST_GAP1;
      ST_GAP1:      state_d = ST_IDLE;
      ST_INIT_REQ:  state_d = ST_INIT_WAIT;
      ST_INIT_WAIT: if (broken_i) state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      hs_ping_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (hs_start) hs_ping_q <= pend_i;
    end
  end

  assign state_o   = state_q;
  assign ack_o     = (state_q == ST_ACK);
  assign integ_o   = broken_i & ~is_init(state_q);
  assign alert_o   = (hs_start & ~pend_i) | integ_o;
  assign ping_ok_o = (state_q == ST_ACK) & fall_i & hs_ping_q;

  // R8
  legal_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_legal(state_d));

  // R2
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACK && !fall_i) |=> state_q == ST_ACK);

  // R3
  gap_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_GAP0 |=> state_q == ST_GAP1);

  // R7
  init_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INIT_WAIT && !broken_i) |=> state_q == ST_INIT_WAIT);

endmodule

// File: rtl/diff_alert_rx.sv
module diff_alert_rx
  import dar_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic alert_p_i,
  input  logic alert_n_i,
  input  logic ping_req_i,
  input  logic init_i,
  output logic ping_p_o,
  output logic ping_n_o,
  output logic ack_p_o,
  output logic ack_n_o,
  output logic alert_o,
  output logic ping_ok_o,
  output logic integ_fail_o
);

  logic      rise, fall, broken;
  logic      ping_level, ping_pend, ack_level, in_init;
  rx_state_t state;

  dar_pair_dec u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .p_i      (alert_p_i),
    .n_i      (alert_n_i),
    .rise_o   (rise),
    .fall_o   (fall),
    .broken_o (broken)
  );

  dar_ping_ctl u_ping (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (ping_req_i),
    .ok_i    (ping_ok_o),
    .hold_i  (in_init),
    .level_o (ping_level),
    .pend_o  (ping_pend)
  );

  dar_rx_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_i    (rise),
    .fall_i    (fall),
    .broken_i  (broken),
    .init_i    (init_i),
    .pend_i    (ping_pend),
    .state_o   (state),
    .ack_o     (ack_level),
    .alert_o   (alert_o),
    .ping_ok_o (ping_ok_o),
    .integ_o   (integ_fail_o)
  );

  assign in_init  = is_init(state);
  assign ping_p_o = in_init | ping_level;
  assign ping_n_o = in_init | ~ping_level;
  assign ack_p_o  = in_init | ack_level;
  assign ack_n_o  = in_init | ~ack_level;

  // R6
  integ_ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (integ_fail_o && ack_p_o && !ack_n_o) |=> (ack_p_o && !ack_n_o));

  // R5
  ok_not_alert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ping_ok_o |-> !alert_o);

endmodule

// File: tb/diff_alert_rx_tb_top.sv
module diff_alert_rx_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ap = 1'b0, an = 1'b1, req = 1'b0, init = 1'b0;
  logic pp, pn, kp, kn, al, ok, integ;
  int   checks = 0;
  int   errors = 0;
  logic plev = 1'b0;

  always #5 clk = ~clk;

  diff_alert_rx dut_i (
    .clk(clk), .rst_n(rst_n), .alert_p_i(ap), .alert_n_i(an),
    .ping_req_i(req), .init_i(init), .ping_p_o(pp), .ping_n_o(pn),
    .ack_p_o(kp), .ack_n_o(kn), .alert_o(al), .ping_ok_o(ok),
    .integ_fail_o(integ)
  );

  function automatic logic [6:0] ex(input logic pl, input logic ak, input logic a,
                                    input logic o, input logic ig);
    return {pl, ~pl, ak, ~ak, a, o, ig};
  endfunction

  task automatic chk(input string tag, input logic [6:0] exp);
    logic [6:0] act;
    @(negedge clk);
    act = {pp, pn, kp, kn, al, ok, integ};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic adv();
    @(posedge clk); #1;
  endtask

  task automatic set_alert(input logic lvl);
    ap = lvl; an = ~lvl;
  endtask

  task automatic t_reset();
    chk("R1 reset", ex(1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
  endtask

  task automatic t_alert();
    set_alert(1'b1);
    chk("R2 rise alert", ex(plev, 1'b0, 1'b1, 1'b0, 1'b0)); adv();
    chk("R2 ack up", ex(plev, 1'b1, 1'b0, 1'b0, 1'b0)); adv();
    chk("R2 ack held", ex(plev, 1'b1, 1'b0, 1'b0, 1'b0)); adv();
    set_alert(1'b0);
    chk("R2 fall seen", ex(plev, 1'b1, 1'b0, 1'b0, 1'b0)); adv();
    set_alert(1'b1);
    chk("R3 pause ignores rise", ex(plev, 1'b0, 1'b0, 1'b0, 1'b0)); adv();
    set_alert(1'b0);
    chk("R3 second pause", ex(plev, 1'b0, 1'b0, 1'b0, 1'b0)); adv();
    chk("R3 idle quiet", ex(plev, 1'b0, 1'b0, 1'b0, 1'b0));
  endtask

  task automatic t_ping();
    req = 1'b1;
    chk("R4 before flip", ex(plev, 1'b0, 1'b0, 1'b0, 1'b0)); adv();
    plev = ~plev;
    chk("R4 flipped", ex(plev, 1'b0, 1'b0, 1'b0, 1'b0)); adv();
    chk("R4 single flip", ex(plev, 1'b0, 1'b0, 1'b0, 1'b0)); adv();
    set_alert(1'b1);
    chk("R5 answer no alert", ex(plev, 1'b0, 1'b0, 1'b0, 1'b0)); adv();
    set_alert(1'b0);
    chk("R5 ping ok", ex(plev, 1'b1, 1'b0, 1'b1, 1'b0)); adv();
    req = 1'b0;
    chk("R5 ok one cycle", ex(plev, 1'b0, 1'b0, 1'b0, 1'b0)); adv(); adv();
    chk("R4 no flip after", ex(plev, 1'b0, 1'b0, 1'b0, 1'b0));
  endtask

  task automatic t_collide();
    req = 1'b1; set_alert(1'b1);
    chk("R5 collide alert", ex(plev, 1'b0, 1'b1, 1'b0, 1'b0)); adv();
    plev = ~plev;
    chk("R5 collide flip", ex(plev, 1'b1, 1'b0, 1'b0, 1'b0)); adv();
    set_alert(1'b0);
    chk("R5 collide no ok", ex(plev, 1'b1, 1'b0, 1'b0, 1'b0)); adv(); adv(); adv();
    set_alert(1'b1);
    chk("R5 later answer", ex(plev, 1'b0, 1'b0, 1'b0, 1'b0)); adv();
    set_alert(1'b0);
    chk("R5 later ok", ex(plev, 1'b1, 1'b0, 1'b1, 1'b0)); adv();
    req = 1'b0; adv(); adv();
  endtask

  task automatic t_integ();
    ap = 1'b1; an = 1'b1;
    chk("R6 idle equal", ex(plev, 1'b0, 1'b1, 1'b0, 1'b1)); adv();
    set_alert(1'b0);
    chk("R6 cleared", ex(plev, 1'b0, 1'b0, 1'b0, 1'b0)); adv();
    set_alert(1'b1); adv();
    ap = 1'b0; an = 1'b0;
    chk("R6 during ack", ex(plev, 1'b1, 1'b1, 1'b0, 1'b1)); adv();
    set_alert(1'b1);
    chk("R6 ack kept", ex(plev, 1'b1, 1'b0, 1'b0, 1'b0)); adv();
    set_alert(1'b0); adv(); adv(); adv();
  endtask

  task automatic t_init();
    init = 1'b1;
    chk("R7 trigger cycle", ex(plev, 1'b0, 1'b0, 1'b0, 1'b0)); adv();
    init = 1'b0;
    chk("R7 pairs equal", 7'b1111000); adv();
    chk("R7 waiting", 7'b1111000); adv();
    ap = 1'b1; an = 1'b1;
    chk("R7 reply not flagged", 7'b1111000); adv();
    set_alert(1'b0);
    chk("R7 back normal", ex(plev, 1'b0, 1'b0, 1'b0, 1'b0));
    adv();
    set_alert(1'b1);
    chk("R8 alert after init", ex(plev, 1'b0, 1'b1, 1'b0, 1'b0)); adv();
    set_alert(1'b0); adv(); adv(); adv();
    set_alert(1'b1);
    chk("R8 alert after handshake", ex(plev, 1'b0, 1'b1, 1'b0, 1'b0)); adv();
    set_alert(1'b0); adv(); adv(); adv();
  endtask

  initial begin
    #200000ns;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    adv();
    t_alert();
    adv();
    t_ping();
    adv();
    t_collide();
    t_integ();
    t_init();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule